// File: doc/BRIEF.md
# Dual-Issue Pairing and Interlock Unit

This block sits between decode and the two execution lanes of an in-order dual-issue core. Each cycle it looks at the two oldest decoded instructions, called slot 0 (older) and slot 1 (younger). It decides whether both leave together, one per lane, or whether only the older one leaves on lane A while lane B gets a bubble. When the instructions depend on each other, the younger one stays in slot 1. The front end then shifts it into slot 0 for the next cycle. Each lane has EX, MEM and WB stages. The unit receives the destination tags that are in flight in those stages.

The core may run in one of two forwarding configurations. With cross-lane bypassing, results in the other lane's stages reach a consumer without delay. Without cross-lane bypassing, only same-lane paths exist. In that case any source that matches a pending write in the other lane holds both lanes until that write has left WB. The held pair is evaluated again every cycle, because the decision is purely combinational on the current inputs. The configuration input is adopted only while the downstream stages are empty, so that in-flight instructions never see a change of rule.

Top module: `dual_issue_pair_ctl`

## Requirements
- R1: Reset places the active configuration in interlock mode, whatever the level of `fwd_cfg`.
- R2: When both slots are valid and independent, lane A takes slot 0 and lane B takes slot 1. Neither lane receives a nop and there is no stall.
- R3: When slot 0 writes (`s0_wr`=1) a register that slot 1 reads through an enabled source, the pair is split. Lane A takes slot 0 (`lane_a_slot`=0), and `nop_b`=1.
- R4: When both slots write the same destination tag, the pair is split in the same way as in R3.
- R5: A source whose use bit is 0 never creates an intra-pair dependency or a cross-lane stall, whatever its tag.
- R6: When exactly one slot is valid, it goes to lane A and `nop_b`=1. `lane_a_slot` reports the slot index: 0 or 1.
- R7: In interlock mode, a stall occurs when an enabled source of an instruction placed on one lane matches a valid destination in any stage of the other lane. Stage index 0 is EX, 1 is MEM and 2 is WB, and stage i uses tag bits [i*TAG_W +: TAG_W]. During a stall neither lane takes an instruction, and `nop_a` and `nop_b` are both 1.
- R8: A held pair is evaluated again every cycle. The stall drops in the first cycle in which the producing entry is no longer present in any stage of the other lane.
- R9: A match against a stage of the instruction's own lane never stalls.
- R10: In cross-lane forwarding mode, matches against the other lane's stages never stall.
- R11: `fwd_cfg` (1 = cross-lane forwarding, 0 = interlock) is copied into the active mode only at a clock edge where all stage valid bits of both lanes are 0. At any other edge the active mode is kept.
- R12: When a pair is split, only slot 0's sources are checked against the other lane's stages. A match that slot 1 would have had on lane B does not stall.
- R13: With no valid slot, both lanes get a nop and `stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fwd_cfg | input | 1 | Requested configuration: 1 = cross-lane forwarding, 0 = interlock |
| s0_vld | input | 1 | Older slot holds an instruction |
| s0_wr | input | 1 | Older slot writes a register |
| s0_rd | input | TAG_W | Older slot destination tag |
| s0_ra_use | input | 1 | Older slot reads its first source |
| s0_ra | input | TAG_W | Older slot first source tag |
| s0_rb_use | input | 1 | Older slot reads its second source |
| s0_rb | input | TAG_W | Older slot second source tag |
| s1_vld | input | 1 | Younger slot holds an instruction |
| s1_wr | input | 1 | Younger slot writes a register |
| s1_rd | input | TAG_W | Younger slot destination tag |
| s1_ra_use | input | 1 | Younger slot reads its first source |
| s1_ra | input | TAG_W | Younger slot first source tag |
| s1_rb_use | input | 1 | Younger slot reads its second source |
| s1_rb | input | TAG_W | Younger slot second source tag |
| a_stg_vld | input | NSTG | Lane A stages holding a register write (0 = EX) |
| a_stg_rd | input | NSTG*TAG_W | Lane A in-flight destination tags |
| b_stg_vld | input | NSTG | Lane B stages holding a register write (0 = EX) |
| b_stg_rd | input | NSTG*TAG_W | Lane B in-flight destination tags |
| lane_a_take | output | 1 | Lane A issues an instruction this cycle |
| lane_a_slot | output | 1 | Slot sent to lane A (0 unless slot 1 goes alone) |
| lane_b_take | output | 1 | Lane B issues slot 1 this cycle |
| nop_a | output | 1 | Lane A receives a bubble |
| nop_b | output | 1 | Lane B receives a bubble |
| stall | output | 1 | Both lanes held on a cross-lane interlock |

## Verification
Two decisions can arise in the same cycle: splitting a dependent pair, and the cross-lane interlock. The pair-split result decides which instruction lands on lane B, and so whether the interlock applies at all. The bench provokes this by giving slot 1 both a dependency on slot 0 and a match in lane A's stages. Only the split may follow from that. A pair that is independent but carries a cross-lane match must stall instead. The second overlap is a configuration request that arrives while stages are busy, together with a pending interlock. A behavioural model predicts every output on every cycle and tracks when the mode is allowed to change.

// File: rtl/dip_pkg.sv
package dip_pkg;

    typedef enum logic {
        DIP_MODE_LOCK = 1'b0,
        DIP_MODE_XFWD = 1'b1
    } dip_mode_e;

    typedef struct packed {
        dip_mode_e mode;
    } dip_state_t;

endpackage

// File: rtl/dip_pair_dep.sv
module dip_pair_dep #(
    parameter int TAG_W = 5
) (
    input  logic             old_wr,
    input  logic [TAG_W-1:0] old_rd,
    input  logic             yng_wr,
    input  logic [TAG_W-1:0] yng_rd,
    input  logic             yng_ra_use,
    input  logic [TAG_W-1:0] yng_ra,
    input  logic             yng_rb_use,
    input  logic [TAG_W-1:0] yng_rb,
    output logic             raw_dep,
    output logic             waw_dep
);
    // younger consumer reading the older producer's result
    always_comb begin
        raw_dep = old_wr && ((yng_ra_use && (yng_ra == old_rd)) ||
                             (yng_rb_use && (yng_rb == old_rd)));
        waw_dep = old_wr && yng_wr && (yng_rd == old_rd);
    end
endmodule

// File: rtl/dip_xlane_hit.sv
module dip_xlane_hit #(
    parameter int TAG_W = 5,
    parameter int NSTG  = 3
) (
    input  logic                  chk_en,
    input  logic                  ra_use,
    input  logic [TAG_W-1:0]      ra,
    input  logic                  rb_use,
    input  logic [TAG_W-1:0]      rb,
    input  logic [NSTG-1:0]       stg_vld,
    input  logic [NSTG*TAG_W-1:0] stg_rd,
    output logic                  hit
);
    logic [NSTG-1:0] stg_match;

    for (genvar st = 0; st < NSTG; st++) begin : g_stg
        logic [TAG_W-1:0] tag_w;
        assign tag_w = stg_rd[st*TAG_W +: TAG_W];
        assign stg_match[st] = stg_vld[st] &&
                               ((ra_use && (ra == tag_w)) ||
                                (rb_use && (rb == tag_w)));
    end

    assign hit = chk_en && (|stg_match);
endmodule

// File: rtl/dual_issue_pair_ctl.sv
module dual_issue_pair_ctl
    import dip_pkg::*;
#(
    parameter int TAG_W = 5,
    parameter int NSTG  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fwd_cfg,
    input  logic                  s0_vld,
    input  logic                  s0_wr,
    input  logic [TAG_W-1:0]      s0_rd,
    input  logic                  s0_ra_use,
    input  logic [TAG_W-1:0]      s0_ra,
    input  logic                  s0_rb_use,
    input  logic [TAG_W-1:0]      s0_rb,
    input  logic                  s1_vld,
    input  logic                  s1_wr,
    input  logic [TAG_W-1:0]      s1_rd,
    input  logic                  s1_ra_use,
    input  logic [TAG_W-1:0]      s1_ra,
    input  logic                  s1_rb_use,
    input  logic [TAG_W-1:0]      s1_rb,
    input  logic [NSTG-1:0]       a_stg_vld,
    input  logic [NSTG*TAG_W-1:0] a_stg_rd,
    input  logic [NSTG-1:0]       b_stg_vld,
    input  logic [NSTG*TAG_W-1:0] b_stg_rd,
    output logic                  lane_a_take,
    output logic                  lane_a_slot,
    output logic                  lane_b_take,
    output logic                  nop_a,
    output logic                  nop_b,
    output logic                  stall
);
    localparam int NLANE = 2;
    localparam int STG_W = NSTG * TAG_W;

    dip_state_t st_d, st_q;

    logic raw_dep, waw_dep;
    logic pipe_empty;
    logic a_cand, a_sel, b_cand;

    // per-lane candidate sources and the opposite lane's stages
    logic [NLANE-1:0] cand_ra_use, cand_rb_use, lane_hit;
    logic [TAG_W-1:0] cand_ra [NLANE];
    logic [TAG_W-1:0] cand_rb [NLANE];
    logic [NSTG-1:0]  oth_vld [NLANE];
    logic [STG_W-1:0] oth_rd  [NLANE];

    dip_pair_dep #(.TAG_W(TAG_W)) u_dep (
        .old_wr     (s0_wr),
        .old_rd     (s0_rd),
        .yng_wr     (s1_wr),
        .yng_rd     (s1_rd),
        .yng_ra_use (s1_ra_use),
        .yng_ra     (s1_ra),
        .yng_rb_use (s1_rb_use),
        .yng_rb     (s1_rb),
        .raw_dep    (raw_dep),
        .waw_dep    (waw_dep)
    );

    // lane A carries slot 1 only when slot 0 is empty
    always_comb begin
        a_sel  = !s0_vld;
        a_cand = s0_vld || s1_vld;
        b_cand = s0_vld && s1_vld && !raw_dep && !waw_dep;

        cand_ra_use[0] = a_sel ? s1_ra_use : s0_ra_use;
        cand_ra[0]     = a_sel ? s1_ra     : s0_ra;
        cand_rb_use[0] = a_sel ? s1_rb_use : s0_rb_use;
        cand_rb[0]     = a_sel ? s1_rb     : s0_rb;
        oth_vld[0]     = b_stg_vld;
        oth_rd[0]      = b_stg_rd;

        cand_ra_use[1] = s1_ra_use;
        cand_ra[1]     = s1_ra;
        cand_rb_use[1] = s1_rb_use;
        cand_rb[1]     = s1_rb;
        oth_vld[1]     = a_stg_vld;
        oth_rd[1]      = a_stg_rd;
    end

    for (genvar ln = 0; ln < NLANE; ln++) begin : g_lane
        dip_xlane_hit #(.TAG_W(TAG_W), .NSTG(NSTG)) u_hit (
            .chk_en  (st_q.mode == DIP_MODE_LOCK),
            .ra_use  (cand_ra_use[ln]),
            .ra      (cand_ra[ln]),
            .rb_use  (cand_rb_use[ln]),
            .rb      (cand_rb[ln]),
            .stg_vld (oth_vld[ln]),
            .stg_rd  (oth_rd[ln]),
            .hit     (lane_hit[ln])
        );
    end

    always_comb begin
        pipe_empty = !(|a_stg_vld) && !(|b_stg_vld);
        st_d = st_q;
        if (pipe_empty) begin
            st_d.mode = fwd_cfg ? DIP_MODE_XFWD : DIP_MODE_LOCK;
        end

        stall       = (a_cand && lane_hit[0]) || (b_cand && lane_hit[1]);
        lane_a_take = a_cand && !stall;
        lane_b_take = b_cand && !stall;
        lane_a_slot = lane_a_take && a_sel;
        nop_a       = !lane_a_take;
        nop_b       = !lane_b_take;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: DIP_MODE_LOCK};
        end else begin
            st_q <= st_d;
        end
    end

    // R2: lane B only ever carries slot 1 beside slot 0 on lane A
    a_r2_b_needs_a: assert property (@(posedge clk) disable iff (!rst_n)
        lane_b_take |-> (lane_a_take && !lane_a_slot));

    // R3: a read-after-write pair never fills lane B
    a_r3_raw_split: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_vld && s1_vld && raw_dep) |-> !lane_b_take);

    // R4: two writers of one tag never leave together
    a_r4_waw_split: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_vld && s1_vld && waw_dep) |-> !lane_b_take);

    // R7: a stall empties both lanes
    a_r7_stall_bubbles: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (nop_a && nop_b));

    // R10: forwarding mode never interlocks
    a_r10_fwd_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == DIP_MODE_XFWD) |-> !stall);

    // R11: busy stages freeze the active mode
    a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((|a_stg_vld) || (|b_stg_vld)) |=> $stable(st_q.mode));

    // R13: empty slots give bubbles and no stall
    a_r13_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!s0_vld && !s1_vld) |-> (!stall && nop_a && nop_b));

endmodule

// File: tb/dual_issue_pair_ctl_tb_top.sv
module dual_issue_pair_ctl_tb_top;
    localparam int TW = 5;
    localparam int NS = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg = 1'b0;
    logic [18:0] s0v = '0;
    logic [18:0] s1v = '0;
    logic [NS-1:0] av = '0;
    logic [NS-1:0] bv = '0;
    logic [NS*TW-1:0] ar = '0;
    logic [NS*TW-1:0] br = '0;

    logic o_at, o_as, o_bt, o_na, o_nb, o_st;
    logic m_mode;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dual_issue_pair_ctl #(.TAG_W(TW), .NSTG(NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .fwd_cfg(cfg),
        .s0_vld(s0v[18]), .s0_wr(s0v[17]), .s0_rd(s0v[16:12]),
        .s0_ra_use(s0v[11]), .s0_ra(s0v[10:6]), .s0_rb_use(s0v[5]), .s0_rb(s0v[4:0]),
        .s1_vld(s1v[18]), .s1_wr(s1v[17]), .s1_rd(s1v[16:12]),
        .s1_ra_use(s1v[11]), .s1_ra(s1v[10:6]), .s1_rb_use(s1v[5]), .s1_rb(s1v[4:0]),
        .a_stg_vld(av), .a_stg_rd(ar), .b_stg_vld(bv), .b_stg_rd(br),
        .lane_a_take(o_at), .lane_a_slot(o_as), .lane_b_take(o_bt),
        .nop_a(o_na), .nop_b(o_nb), .stall(o_st)
    );

    function automatic logic [18:0] ins(input logic v, input logic w, input int rd,
                                        input logic ua, input int ra,
                                        input logic ub, input int rb);
        return {v, w, rd[4:0], ua, ra[4:0], ub, rb[4:0]};
    endfunction

    // behavioural model of the active configuration
    always @(posedge clk) begin
        if (!rst_n) m_mode <= 1'b0;
        else if (av == '0 && bv == '0) m_mode <= cfg;
    end

    // does an instruction on one lane read a tag in flight on the other lane
    function automatic bit xhit(input logic [18:0] s, input logic [NS-1:0] v,
                                input logic [NS*TW-1:0] r);
        bit h = 0;
        for (int i = 0; i < NS; i++) begin
            if (v[i] && s[11] && s[10:6] == r[i*TW +: TW]) h = 1;
            if (v[i] && s[5] && s[4:0] == r[i*TW +: TW]) h = 1;
        end
        return h;
    endfunction

    // expected {a_take, a_slot, b_take, nop_a, nop_b, stall}
    function automatic logic [5:0] model();
        bit both, dep, stl, at, bt, sl;
        both = s0v[18] && s1v[18];
        dep = s0v[17] && ((s1v[11] && s1v[10:6] == s0v[16:12]) ||
                          (s1v[5] && s1v[4:0] == s0v[16:12]) ||
                          (s1v[17] && s1v[16:12] == s0v[16:12]));
        at = s0v[18] || s1v[18];
        sl = !s0v[18] && s1v[18];
        bt = both && !dep;
        stl = 0;
        if (!m_mode) begin
            if (at && xhit(sl ? s1v : s0v, bv, br)) stl = 1;
            if (bt && xhit(s1v, av, ar)) stl = 1;
        end
        if (stl) begin at = 0; bt = 0; sl = 0; end
        return {at, sl, bt, !at, !bt, stl};
    endfunction

    task automatic step(input string req);
        logic [5:0] exp_v, act_v;
        @(posedge clk);
        @(negedge clk);
        exp_v = model();
        act_v = {o_at, o_as, o_bt, o_na, o_nb, o_st};
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: {a_take,a_slot,b_take,nop_a,nop_b,stall} actual %b expected %b",
                     req, act_v, exp_v);
        end
    endtask

    task automatic idle();
        s0v = '0; s1v = '0; av = '0; bv = '0; ar = '0; br = '0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: during reset the mode is interlock even with cfg=1
        cfg = 1'b1;
        s0v = ins(1, 1, 2, 1, 9, 0, 0);
        bv[0] = 1'b1; br[0 +: TW] = 5'd9;
        step("R1");
        step("R1");
        idle(); cfg = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        step("R13");
        step("R1");

        // R2: independent pair
        s0v = ins(1, 1, 2, 1, 1, 1, 0);
        s1v = ins(1, 1, 3, 1, 4, 1, 5);
        step("R2");
        // R3: slot 1 reads slot 0's result through each source
        s1v = ins(1, 1, 4, 1, 2, 1, 0);
        step("R3");
        s1v = ins(1, 1, 5, 1, 0, 1, 2);
        step("R3");
        // R3 negative: slot 0 does not write
        s0v = ins(1, 0, 2, 1, 1, 1, 0);
        step("R3");
        // R5: matching tag with use bit clear
        s0v = ins(1, 1, 2, 1, 1, 1, 0);
        s1v = ins(1, 1, 6, 0, 2, 0, 2);
        step("R5");
        // R4: same destination
        s1v = ins(1, 1, 2, 1, 7, 1, 8);
        step("R4");
        // R6: single valid slot
        s1v = '0;
        step("R6");
        s0v = '0; s1v = ins(1, 1, 3, 1, 4, 0, 0);
        step("R6");
        s0v = '0; s1v = '0;
        step("R13");

        // R7: lane A instruction vs lane B stages, each stage
        s0v = ins(1, 1, 2, 1, 9, 0, 0);
        for (int i = 0; i < NS; i++) begin
            bv = '0; bv[i] = 1'b1; br = '0; br[i*TW +: TW] = 5'd9;
            step("R7");
        end
        // R5: source in flight but not used
        s0v = ins(1, 1, 2, 0, 9, 0, 9);
        step("R5");
        // R7: lane B instruction vs lane A stages
        bv = '0; br = '0;
        s0v = ins(1, 1, 2, 1, 1, 0, 0);
        s1v = ins(1, 1, 3, 0, 0, 1, 10);
        av[1] = 1'b1; ar[1*TW +: TW] = 5'd10;
        step("R7");
        // R9: same-lane match
        s1v = '0;
        s0v = ins(1, 1, 2, 1, 10, 0, 0);
        step("R9");
        // R12: split pair where slot 1 matches lane A stage
        s0v = ins(1, 1, 2, 1, 1, 0, 0);
        s1v = ins(1, 1, 3, 1, 2, 1, 10);
        step("R12");
        // R7 vs R12: same slot 1 without the dependency stalls
        s1v = ins(1, 1, 3, 1, 4, 1, 10);
        step("R7");
        idle();

        // R8: producer moves EX -> MEM -> WB -> gone
        s0v = ins(1, 1, 2, 1, 11, 0, 0);
        bv = 3'b001; br = '0; br[0 +: TW] = 5'd11;
        step("R8");
        bv = 3'b010; br = '0; br[1*TW +: TW] = 5'd11;
        step("R8");
        bv = 3'b100; br = '0; br[2*TW +: TW] = 5'd11;
        step("R8");
        bv = '0; br = '0;
        step("R8");

        // R11: request forwarding while busy; mode must hold
        cfg = 1'b1;
        bv = 3'b001; br[0 +: TW] = 5'd11;
        step("R11");
        step("R11");
        // empty cycle adopts the request
        idle();
        step("R11");
        // R10: cross-lane match no longer stalls
        s0v = ins(1, 1, 2, 1, 11, 0, 0);
        s1v = ins(1, 1, 3, 1, 12, 0, 0);
        bv = 3'b100; br[2*TW +: TW] = 5'd11;
        av = 3'b001; ar[0 +: TW] = 5'd12;
        step("R10");
        // R11: back to interlock requested while busy
        cfg = 1'b0;
        step("R11");
        step("R10");
        idle();
        step("R11");
        s0v = ins(1, 1, 2, 1, 11, 0, 0);
        bv = 3'b001; br[0 +: TW] = 5'd11;
        step("R11");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule